// File: doc/BRIEF.md
# Reloadable Down-Counter Timer

A 32-bit timer peripheral with a small memory-mapped register window. Software programs a start count and a reload count and then sets a run bit. The counter then steps down by one on every clock. When it reaches zero, the next clock reloads it from the reload register and latches a pending event. That one mechanism covers three uses. Loading all ones with the interrupt off gives a free-running time base; software inverts the value it reads to get a rising count. Writing the same period to both counts gives a periodic tick. Writing the current-value register for each deadline gives one-shot events.

The bus is a single-beat request port with word offsets. Every request, read or write, is answered by `ready_o` one clock later. Read data appears with that ready. The interrupt line is a level: it stays high while an event is pending and interrupts are enabled, until software clears the pending flag.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, value, reload and status registers all read zero, and `irq_o` is low.
- R2: The control register sits at offset 0x0. Bit 0 is the run enable and bit 3 is the interrupt enable. All other bits read zero and ignore writes.
- R3: The value register is at 0x4, the reload register at 0x8 and the status register at 0xC. `ready_o` rises exactly one clock after each request. Read data is valid with it and reflects register contents before that clock's update. Address bits [1:0] are ignored.
- R4: While the run bit is set and the value is nonzero, the value drops by one each clock. While the run bit is clear, the value holds.
- R5: While running with a value of zero, the next clock loads the reload register into the value and sets the pending status bit in that same clock.
- R6: A write to the value register takes priority over the decrement or reload in the same clock. That clock sets no pending status.
- R7: Status bit 0 reads 1 while an event is pending. A write with bit 0 set clears it, and a write with bit 0 clear has no effect. A new event in the same clock as a clear keeps the bit set.
- R8: `irq_o` is high exactly when the status bit is pending and the interrupt enable is set. It stays high until the status is cleared or the interrupt enable is dropped.
- R9: Offsets at or above 0x10 read zero, and writes to them change no register.
- R10: With the value and reload both all ones and the run bit set, the bitwise inverse of the value read counts the clocks since enabling. When the count passes zero it wraps back to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one clock per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with ready_o |
| ready_o | output | 1 | Access complete, one clock after req_i |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume each request is held for exactly one clock, with `we_i`, `addr_i` and `wdata_i` stable during it, and that at most one access happens per clock. The bench always drives requests on the falling edge and drops them after a single rising edge, so every access occupies one clock. Expected read values are derived by counting rising edges from the control write that starts the counter. Where the outcome depends on the edge that writes a register, tests stop the timer first.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_IE_BIT = 3;
  localparam int unsigned STAT_PEND_BIT = 0;
  localparam int unsigned WORD_LSB = 2;
  localparam int unsigned MAP_BITS = 4;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_VALUE  = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic ctrl;
    logic value;
    logic reload;
    logic status;
  } wr_strobe_t;

endpackage

// File: rtl/tmr_bus_if.sv
module tmr_bus_if
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic              ie_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] reload_i,
  input  logic              status_i,
  output wr_strobe_t        wr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o
);

  localparam int unsigned HI_W = ADDR_W - MAP_BITS;

  logic              mapped;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_next;
  logic              hit_wr;
  logic              unused_lo;

  assign unused_lo = ^addr_i[WORD_LSB-1:0];
  assign mapped    = (addr_i[ADDR_W-1:MAP_BITS] == {HI_W{1'b0}});
  assign sel       = reg_sel_e'(addr_i[MAP_BITS-1:WORD_LSB]);
  assign hit_wr    = req_i & we_i & mapped;

  always_comb begin
    wr_o.ctrl   = hit_wr && (sel == SEL_CTRL);
    wr_o.value  = hit_wr && (sel == SEL_VALUE);
    wr_o.reload = hit_wr && (sel == SEL_RELOAD);
    wr_o.status = hit_wr && (sel == SEL_STATUS);
  end

  always_comb begin
    rd_next = '0;
    if (mapped) begin
      unique case (sel)
        SEL_CTRL: begin
          rd_next[CTRL_EN_BIT] = en_i;
          rd_next[CTRL_IE_BIT] = ie_i;
        end
        SEL_VALUE:  rd_next = value_i;
        SEL_RELOAD: rd_next = reload_i;
        SEL_STATUS: rd_next[STAT_PEND_BIT] = status_i;
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      ready_o <= req_i;
      if (req_i) rdata_o <= we_i ? '0 : rd_next;
    end
  end

  AST_READY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o); // R3
  AST_READY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |=> (rdata_o == '0)); // R9
  AST_NO_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mapped |-> (wr_o == '0)); // R9

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_value_i,
  input  logic              wr_reload_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] value_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              zero_evt_o
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] value_q;
  logic [DATA_W-1:0] reload_q;
  logic              at_zero;

  assign at_zero    = (value_q == '0);
  // a direct value write suppresses both the step and the event
  assign zero_evt_o = en_i & ~wr_value_i & at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
    end else if (wr_reload_i) begin
      reload_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q <= '0;
    end else if (wr_value_i) begin
      value_q <= wdata_i;
    end else if (en_i) begin
      value_q <= at_zero ? reload_q : value_q - ONE;
    end
  end

  assign value_o  = value_q;
  assign reload_o = reload_q;

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wr_value_i && value_q != '0) |=> (value_q == $past(value_q) - ONE)); // R4
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_value_i) |=> $stable(value_q)); // R4
  AST_RELOAD_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wr_value_i && value_q == '0) |=> (value_q == $past(reload_q))); // R5
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_value_i |=> (value_q == $past(wdata_i))); // R6

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic status_o,
  output logic irq_o
);

  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign status_o = pend_q;
  assign irq_o    = pend_q & ie_i;

  AST_EVENT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> status_o); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !status_o); // R7
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !clr_i) |=> status_o); // R7
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o && !set_i) |=> !status_o); // R7

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              irq_o
);

  wr_strobe_t        wr;
  logic              en_q;
  logic              ie_q;
  logic [DATA_W-1:0] value;
  logic [DATA_W-1:0] reload;
  logic              status;
  logic              zero_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (wr.ctrl) begin
      en_q <= wdata_i[CTRL_EN_BIT];
      ie_q <= wdata_i[CTRL_IE_BIT];
    end
  end

  tmr_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .en_i     (en_q),
    .ie_i     (ie_q),
    .value_i  (value),
    .reload_i (reload),
    .status_i (status),
    .wr_o     (wr),
    .rdata_o  (rdata_o),
    .ready_o  (ready_o)
  );

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .wr_value_i  (wr.value),
    .wr_reload_i (wr.reload),
    .wdata_i     (wdata_i),
    .value_o     (value),
    .reload_o    (reload),
    .zero_evt_o  (zero_evt)
  );

  tmr_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (zero_evt),
    .clr_i    (wr.status & wdata_i[STAT_PEND_BIT]),
    .ie_i     (ie_q),
    .status_o (status),
    .irq_o    (irq_o)
  );

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr.ctrl && !wdata_i[CTRL_IE_BIT]) |=> !irq_o); // R8
  AST_CTRL_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr.ctrl |=> (en_q == $past(wdata_i[CTRL_EN_BIT]) && ie_q == $past(wdata_i[CTRL_IE_BIT]))); // R2

endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;

  localparam int AW = 12;
  localparam int DW = 32;

  typedef struct {
    bit          chk;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          ready;
  logic          irq;

  int checks = 0;
  int errors = 0;
  item_t sb[$];

  always #2 clk = ~clk;

  tick_timer #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .irq_o(irq)
  );

  // monitor
  always @(negedge clk) begin
    if (rst_n && ready) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected ready: actual 1 expected 0");
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.chk) begin
          checks++;
          if (rdata !== it.exp) begin
            errors++;
            $display("FAIL %s read: actual %h expected %h", it.tag, rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    item_t it;
    it.chk = 1'b0; it.exp = '0; it.tag = "";
    sb.push_back(it);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.chk = 1'b1; it.exp = e; it.tag = tag;
    sb.push_back(it);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq: actual %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk_irq(1'b0, "R1");
    bus_rd(12'h0, 32'h0, "R1");
    bus_rd(12'h4, 32'h0, "R1");
    bus_rd(12'h8, 32'h0, "R1");
    bus_rd(12'hC, 32'h0, "R1");
    // R2 unused control bits ignored
    bus_wr(12'h0, 32'hFFFF_FFF6);
    bus_rd(12'h0, 32'h0, "R2");
    // R3 reload and value registers
    bus_wr(12'h8, 32'h0000_1234);
    bus_rd(12'h8, 32'h0000_1234, "R3");
    bus_wr(12'h4, 32'd100);
    idle(5);
    bus_rd(12'h4, 32'd100, "R4");
    bus_rd(12'h6, 32'd100, "R3");
    // R4 counting
    bus_wr(12'h0, 32'h1);
    idle(10);
    bus_rd(12'h4, 32'd90, "R4");
    bus_wr(12'h0, 32'h0);
    idle(4);
    bus_rd(12'h4, 32'd88, "R4");
    // R5 / R8 reload and interrupt
    bus_wr(12'h8, 32'd3);
    bus_wr(12'h4, 32'd2);
    bus_wr(12'h0, 32'h9);
    idle(2);
    chk_irq(1'b0, "R8");
    idle(1);
    chk_irq(1'b1, "R5");
    bus_rd(12'h4, 32'd3, "R5");
    bus_rd(12'hC, 32'h1, "R7");
    // R8 interrupt masked while pending
    bus_wr(12'h0, 32'h1);
    chk_irq(1'b0, "R8");
    // R7 clear semantics
    bus_wr(12'h0, 32'h0);
    bus_wr(12'hC, 32'h0);
    bus_rd(12'hC, 32'h1, "R7");
    bus_wr(12'h0, 32'h8);
    chk_irq(1'b1, "R8");
    bus_wr(12'hC, 32'h1);
    chk_irq(1'b0, "R7");
    bus_rd(12'hC, 32'h0, "R7");
    // R6 write priority
    bus_wr(12'h0, 32'h0);
    bus_wr(12'h8, 32'd1000);
    bus_wr(12'h4, 32'd500);
    bus_wr(12'h0, 32'h1);
    idle(3);
    bus_wr(12'h4, 32'd50);
    bus_rd(12'h4, 32'd50, "R6");
    bus_rd(12'h4, 32'd49, "R6");
    // R10 free running
    bus_wr(12'h0, 32'h0);
    bus_wr(12'hC, 32'h1);
    bus_wr(12'h8, 32'hFFFF_FFFF);
    bus_wr(12'h4, 32'hFFFF_FFFF);
    bus_wr(12'h0, 32'h1);
    idle(4);
    bus_rd(12'h4, ~32'd4, "R10");
    bus_wr(12'h4, 32'd1);
    idle(1);
    bus_rd(12'h4, 32'h0, "R10");
    bus_rd(12'h4, 32'hFFFF_FFFF, "R10");
    bus_rd(12'hC, 32'h1, "R5");
    chk_irq(1'b0, "R8");
    // R9 unmapped offsets
    bus_wr(12'h0, 32'h0);
    bus_wr(12'h10, 32'h0000_ABCD);
    bus_wr(12'h18, 32'h0000_0055);
    bus_rd(12'h10, 32'h0, "R9");
    bus_rd(12'h18, 32'h0, "R9");
    bus_rd(12'h8, 32'hFFFF_FFFF, "R9");
    // R2 control fields, shutdown
    bus_wr(12'h0, 32'hFFFF_FFFF);
    bus_rd(12'h0, 32'h9, "R2");
    bus_wr(12'h0, 32'h0);
    bus_wr(12'h8, 32'h0);
    bus_rd(12'h8, 32'h0, "R3");
    idle(3);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R3 pending responses: actual %0d expected 0", sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule